// File: doc/BRIEF.md
# GPIO Interrupt Detection and Control

This block turns the synchronized pin values of a GPIO port into interrupt requests. Each line is handled on its own. It can be set to respond to a rising edge, a falling edge, both edges, a high level or a low level. Each line also has its own enable, its own mask and an optional debounce filter. A line in edge mode holds each event in a sticky pending bit until software acknowledges it. A line in level mode shows the live level of its input. All lines feed one combined interrupt output, and a gate bit lets that output through or holds it low.

Software controls the block through a 32-bit register bus. Every per-line setting lives in a pair of addresses. Writing 1s to the set address turns those bits on, and writing 1s to the clear address turns them off. Bits written as 0 leave the setting unchanged. A read is a single-cycle request. The data comes back registered on the following cycle together with a one-cycle valid strobe. The bus has no back-pressure: the block accepts every write and every read request in the cycle it is presented.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every configuration register, the status register and the gate bit read 0, and `irq_out` is 0.
- R2: The setting registers are enable (set 0x00, clear 0x04), mask (0x08/0x0C), edge select (0x10/0x14), polarity (0x18/0x1C), dual-edge (0x20/0x24) and debounce enable (0x28/0x2C). Writing 1s to a set address sets those bits, and writing 1s to a clear address clears them. Bits written as 0 are unchanged. Reading a set address returns the current register value.
- R3: When a line's edge-select bit is 1 and its dual-edge bit is 0, the line latches a pending bit on a rising edge if its polarity bit is 1, and on a falling edge if its polarity bit is 0. The pending bit stays set after the input returns.
- R4: When a line's dual-edge bit is 1, the line latches on both edges, whatever its edge-select and polarity bits say. In that case a steady level never raises status.
- R5: When a line's edge-select and dual-edge bits are both 0, its status bit equals its input level if polarity is 1, or the inverse of that level if polarity is 0. Writing the acknowledge register does not clear it.
- R6: Writing 1s to the acknowledge address 0x34 clears the matching edge pending bits. An event arriving in the same cycle wins over the clear.
- R7: A line whose enable bit is 0 latches no new edge event and reads 0 in the status register at 0x30. Enabling the line later does not reveal events that occurred while it was disabled.
- R8: A line adds to `irq_out` only when it is enabled, its mask bit is 0 and its status bit is 1. The mask has no effect on the status register.
- R9: The gate bit is bit 0 at 0x38 and can be read and written. `irq_out` is the gate bit ANDed with the OR of all unmasked status bits.
- R10: With debounce enabled, the block accepts a change on a line only after the input has differed from the accepted value for DEB_CYCLES consecutive clocks. A shorter pulse is ignored. With debounce off, the block accepts a change one clock after the input changes.
- R11: A read request in one cycle gives `bus_rvalid` high for exactly the next cycle, with `bus_rdata` valid in that cycle. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_rd | input | 1 | Read request for the register bus |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | One-cycle strobe that marks returned read data |
| pin_in | input | N_LINES | Synchronized pin values |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bound checker checks these rules on every cycle:
- `irq_out` stays low while the gate is closed, and it is high only when some unmasked status bit is set.
- The status register never shows a disabled line.
- A pending bit never rises on a line that was disabled.
- An acknowledged pending bit with no new event is clear one cycle later.
- An accepted input value always comes from an earlier raw sample.
- Read data is returned exactly one cycle after the request.

The bench scenarios cover what needs a history of stimulus: the choice of edge by polarity, the dual-edge override of a level setting, a level line that the acknowledge cannot clear, a debounce pulse that is too short to be accepted, and the set/clear register semantics as seen through readback.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int NUM_CFG  = 6;
  localparam int PAIR_STRIDE = 8;

  typedef enum int {
    CFG_EN   = 0,
    CFG_MASK = 1,
    CFG_EDGE = 2,
    CFG_POL  = 3,
    CFG_BOTH = 4,
    CFG_DEB  = 5
  } cfg_idx_e;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'h30;
  localparam logic [ADDR_W-1:0] ADDR_ACK    = 8'h34;
  localparam logic [ADDR_W-1:0] ADDR_GATE   = 8'h38;

  function automatic logic [ADDR_W-1:0] set_addr(input int idx);
    return ADDR_W'(idx * PAIR_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] clr_addr(input int idx);
    return ADDR_W'(idx * PAIR_STRIDE + 4);
  endfunction
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [NUM_CFG-1:0][N_LINES-1:0] cfg_q,
  output logic                            gate_q,
  output logic [N_LINES-1:0]              ack_bits
);
  logic [N_LINES-1:0] wbits;
  assign wbits = bus_wdata[N_LINES-1:0];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (bus_wr && bus_addr == set_addr(g)) begin
        cfg_q[g] <= cfg_q[g] | wbits;
      end else if (bus_wr && bus_addr == clr_addr(g)) begin
        cfg_q[g] <= cfg_q[g] & ~wbits;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else if (bus_wr && bus_addr == ADDR_GATE) begin
      gate_q <= bus_wdata[0];
    end
  end

  assign ack_bits = (bus_wr && bus_addr == ADDR_ACK) ? wbits : '0;
endmodule

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
  parameter int DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic deb_en,
  output logic filt
);
  localparam int CW = $clog2(DEB_CYCLES) + 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt  <= 1'b0;
      cnt_q <= '0;
    end else if (!deb_en) begin
      filt  <= raw;
      cnt_q <= '0;
    end else if (raw != filt) begin
      if (cnt_q == LAST) begin
        filt  <= raw;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] filt,
  input  logic [N_LINES-1:0] en,
  input  logic [N_LINES-1:0] edge_sel,
  input  logic [N_LINES-1:0] pol,
  input  logic [N_LINES-1:0] both,
  input  logic [N_LINES-1:0] ack,
  output logic [N_LINES-1:0] latch,
  output logic [N_LINES-1:0] pend_q,
  output logic [N_LINES-1:0] status
);
  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] rise, fall, evt, edge_mode, level_hit;

  always_comb begin
    rise      = filt & ~prev_q;
    fall      = ~filt & prev_q;
    edge_mode = both | edge_sel;
    evt       = (both & (rise | fall)) |
                (~both & edge_sel & ((pol & rise) | (~pol & fall)));
    latch     = en & evt;
    level_hit = (pol & filt) | (~pol & ~filt);
    status    = en & ((edge_mode & pend_q) | (~edge_mode & level_hit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= filt;
      pend_q <= latch | (pend_q & ~ack);
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES    = 32,
  parameter int DEB_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic [N_LINES-1:0] pin_in,
  output logic               irq_out
);
  logic [NUM_CFG-1:0][N_LINES-1:0] cfg_q;
  logic                            gate_q;
  logic [N_LINES-1:0]              ack_bits;
  logic [N_LINES-1:0]              filt;
  logic [N_LINES-1:0]              latch;
  logic [N_LINES-1:0]              pend_q;
  logic [N_LINES-1:0]              status;
  logic [DATA_W-1:0]               rd_mux;

  gpio_irq_regs #(.N_LINES(N_LINES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cfg_q    (cfg_q),
    .gate_q   (gate_q),
    .ack_bits (ack_bits)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    gpio_irq_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (pin_in[i]),
      .deb_en(cfg_q[CFG_DEB][i]),
      .filt  (filt[i])
    );
  end

  gpio_irq_detect #(.N_LINES(N_LINES)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .filt    (filt),
    .en      (cfg_q[CFG_EN]),
    .edge_sel(cfg_q[CFG_EDGE]),
    .pol     (cfg_q[CFG_POL]),
    .both    (cfg_q[CFG_BOTH]),
    .ack     (ack_bits),
    .latch   (latch),
    .pend_q  (pend_q),
    .status  (status)
  );

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_CFG; k++) begin
      if (bus_addr == set_addr(k)) rd_mux[N_LINES-1:0] = cfg_q[k];
    end
    if (bus_addr == ADDR_STATUS) rd_mux[N_LINES-1:0] = status;
    if (bus_addr == ADDR_GATE)   rd_mux[0] = gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign irq_out = gate_q & (|(status & ~cfg_q[CFG_MASK]));
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int N_LINES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_rd,
  input logic               bus_rvalid,
  input logic [N_LINES-1:0] pin_in,
  input logic               irq_out,
  input logic               gate,
  input logic [N_LINES-1:0] en,
  input logic [N_LINES-1:0] mask,
  input logic [N_LINES-1:0] ack,
  input logic [N_LINES-1:0] filt,
  input logic [N_LINES-1:0] latch,
  input logic [N_LINES-1:0] pend,
  input logic [N_LINES-1:0] status
);
  // R9: a closed gate holds the combined output low
  assert_gate_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> !irq_out);

  // R8: the output needs some unmasked status bit
  assert_irq_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((status & ~mask) != '0));

  // R7: status never shows a disabled line
  assert_status_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~en) == '0);

  // R7: no pending bit rises on a line that was disabled
  assert_disabled_no_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(en)) == '0));

  // R6: acknowledged bit with no new event is cleared next cycle
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |=> ((pend & $past(ack & ~latch)) == '0));

  // R10: an accepted value always equals an earlier raw sample
  assert_filt_from_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((filt ^ $past(filt)) & (filt ^ $past(pin_in))) == '0));

  // R11: read data strobe follows the request by one cycle
  assert_rvalid_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  assert_rvalid_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_rvalid(bus_rvalid),
  .pin_in    (pin_in),
  .irq_out   (irq_out),
  .gate      (gate_q),
  .en        (cfg_q[0]),
  .mask      (cfg_q[1]),
  .ack       (ack_bits),
  .filt      (filt),
  .latch     (latch),
  .pend      (pend_q),
  .status    (status)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int N = 32;
  localparam int DEB = 4;

  localparam logic [7:0] A_EN_S = 8'h00, A_EN_C = 8'h04;
  localparam logic [7:0] A_MK_S = 8'h08, A_MK_C = 8'h0C;
  localparam logic [7:0] A_ED_S = 8'h10, A_ED_C = 8'h14;
  localparam logic [7:0] A_PO_S = 8'h18;
  localparam logic [7:0] A_BO_S = 8'h20;
  localparam logic [7:0] A_DB_S = 8'h28;
  localparam logic [7:0] A_ST = 8'h30, A_ACK = 8'h34, A_GATE = 8'h38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [N-1:0] pins = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       req_q[$];

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.N_LINES(N), .DEB_CYCLES(DEB)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pins), .irq_out(irq_out)
  );

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11: unexpected read data %h, expected no data", bus_rdata);
      end else begin
        logic [31:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: read %h, expected %h", r, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] e, input string r);
    @(negedge clk);
    exp_q.push_back(e); req_q.push_back(r);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string r);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s: irq_out %b, expected %b", r, irq_out, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin(input int i, input logic v);
    @(negedge clk);
    pins[i] = v;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    for (int k = 0; k < 6; k++) rd_expect(8'(k * 8), 32'h0, "R1");
    rd_expect(A_ST, 32'h0, "R1");
    rd_expect(A_GATE, 32'h0, "R1");
    chk_irq(1'b0, "R1");

    // R2: set/clear semantics
    wr(A_MK_S, 32'h0000_00F0);
    wr(A_MK_S, 32'h0000_000F);
    rd_expect(A_MK_S, 32'h0000_00FF, "R2");
    wr(A_MK_C, 32'h0000_000C);
    rd_expect(A_MK_S, 32'h0000_00F3, "R2");
    wr(A_MK_C, 32'hFFFF_FFFF);
    rd_expect(A_MK_S, 32'h0, "R2");

    // R9: gate readback
    wr(A_GATE, 32'h1);
    rd_expect(A_GATE, 32'h1, "R9");

    // R3: rising edge on line 0, sticky
    wr(A_ED_S, 32'h1); wr(A_PO_S, 32'h1); wr(A_EN_S, 32'h1);
    rd_expect(A_ST, 32'h0, "R3");
    pin(0, 1'b1); idle(3);
    rd_expect(A_ST, 32'h1, "R3");
    chk_irq(1'b1, "R3");
    pin(0, 1'b0); idle(3);
    rd_expect(A_ST, 32'h1, "R3");
    // R6: acknowledge clears
    wr(A_ACK, 32'h1); idle(1);
    rd_expect(A_ST, 32'h0, "R6");
    chk_irq(1'b0, "R6");

    // R3: falling edge on line 1 (polarity 0)
    wr(A_ED_S, 32'h2); wr(A_EN_S, 32'h2);
    pin(1, 1'b1); idle(3);
    rd_expect(A_ST, 32'h0, "R3");
    pin(1, 1'b0); idle(3);
    rd_expect(A_ST, 32'h2, "R3");
    wr(A_ACK, 32'h2); idle(1);
    rd_expect(A_ST, 32'h0, "R6");

    // R4: dual edge on line 2 overrides level-low setting
    wr(A_BO_S, 32'h4); wr(A_EN_S, 32'h4); idle(2);
    rd_expect(A_ST, 32'h0, "R4");
    pin(2, 1'b1); idle(3);
    rd_expect(A_ST, 32'h4, "R4");
    wr(A_ACK, 32'h4); idle(1);
    rd_expect(A_ST, 32'h0, "R4");
    pin(2, 1'b0); idle(3);
    rd_expect(A_ST, 32'h4, "R4");
    wr(A_ACK, 32'h4); idle(1);
    rd_expect(A_BO_S, 32'h4, "R4");

    // R5: level-high on line 3
    wr(A_PO_S, 32'h8); wr(A_EN_S, 32'h8); idle(2);
    rd_expect(A_ST, 32'h0, "R5");
    pin(3, 1'b1); idle(3);
    rd_expect(A_ST, 32'h8, "R5");
    wr(A_ACK, 32'h8); idle(2);
    rd_expect(A_ST, 32'h8, "R5");
    pin(3, 1'b0); idle(3);
    rd_expect(A_ST, 32'h0, "R5");

    // R7: disabled line 4 latches nothing
    wr(A_ED_S, 32'h10); wr(A_PO_S, 32'h10);
    pin(4, 1'b1); idle(3);
    pin(4, 1'b0); idle(3);
    rd_expect(A_ST, 32'h0, "R7");
    wr(A_EN_S, 32'h10); idle(2);
    rd_expect(A_ST, 32'h0, "R7");
    chk_irq(1'b0, "R7");

    // R8: mask hides line 0 from irq_out but not from status
    wr(A_MK_S, 32'h1);
    pin(0, 1'b1); idle(3);
    pin(0, 1'b0); idle(3);
    rd_expect(A_ST, 32'h1, "R8");
    chk_irq(1'b0, "R8");
    wr(A_MK_C, 32'h1); idle(1);
    chk_irq(1'b1, "R8");

    // R9: gate closes and reopens the output
    wr(A_GATE, 32'h0); idle(1);
    chk_irq(1'b0, "R9");
    wr(A_GATE, 32'h1); idle(1);
    chk_irq(1'b1, "R9");
    wr(A_ACK, 32'h1); idle(1);
    chk_irq(1'b0, "R9");

    // R10: debounce on line 5, rising edge
    wr(A_ED_S, 32'h20); wr(A_PO_S, 32'h20); wr(A_DB_S, 32'h20); wr(A_EN_S, 32'h20);
    pin(5, 1'b1); idle(DEB - 2);
    pin(5, 1'b0); idle(4);
    rd_expect(A_ST, 32'h0, "R10");
    pin(5, 1'b1); idle(DEB + 3);
    rd_expect(A_ST, 32'h20, "R10");
    pin(5, 1'b0); idle(DEB + 3);
    wr(A_ACK, 32'h20); idle(1);
    rd_expect(A_ST, 32'h0, "R10");

    // R11: unused address reads 0, no stray strobe
    rd_expect(8'h3C, 32'h0, "R11");
    idle(2);
    checks++;
    if (bus_rvalid !== 1'b0 || exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11: rvalid %b pending %0d, expected 0 and 0", bus_rvalid, exp_q.size());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule